// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Register Target

This block is a serial-bus target that holds eight byte-wide configuration locations for a clock-distribution control path. A host reaches it over a two-wire open-drain bus (SMBus electrical rules, up to 400 kHz). Every access is an indexed block access. On a write, the host sends a start index, then a byte count, then the data. On a read, the host sets the index, issues a repeated start and the read address. The target then answers with a byte count, followed by data from consecutive locations.

Both bus lines come in as sampled levels. The target drives the data line only through an active-high pull-low enable, so the output buffer stays outside this block. The writable locations go out as one packed control word. Two read-only status bits come in from the surrounding logic. The target's 7-bit address is chosen by a strap pin. That pin is captured on the first rising edge of the power-good input, and the target stays silent until that edge has been seen. The system clock must run at no less than 16 times the bus clock. Each bus line passes through a two-flop synchroniser and then a three-sample agreement filter.

Top module: `smb_cfg_target`

## Requirements
- R1: The device address is 7'h68 when the strap was 0 and 7'h6A when it was 1. The strap value used is the one present at the first rising edge of pwrgd_i after reset. Later strap changes or power-good pulses do not change the address.
- R2: Before the first power-good rise, and for any address byte that does not match, the target does not acknowledge. After a mismatch it ignores all traffic until the next start condition.
- R3: In a write transaction (address with write bit 0, index N, count X, data), the target acknowledges every byte. Data byte k goes to location N+k for k < X. Bytes beyond the X-th are acknowledged but discarded.
- R4: After a repeated start with the read bit (1), the first byte sent is the read-back count. The bytes after it come from locations N, N+1, and onward, most significant bit first.
- R5: A host NACK on a byte sent by the target ends the transmission. The target releases SDA and sends nothing until the next start.
- R6: Location 0 (8 bits, reset 0xFF), location 2 (reset 0xFF) and location 3 (reset 0x10) are read/write. Location 1 reads {status_i[1:0], six RW bits} with the RW bits resetting to 0x02. The output is ctrl_o = {loc3, loc2, 2'b00, loc1[5:0], loc0}.
- R7: Location 4 always reads 0xFF. Location 5 reads 0x01 and location 6 reads 0x04, and writes to them are ignored. Location 7 holds the read-back count in bits [4:0], resetting to 8, with bits [7:5] reading 0. Any index above 7 reads 0xFF.
- R8: The index advances by one after every stored or sent data byte. Writes to indices above 7 change nothing.
- R9: The pull-low enable only rises while SCL is low.
- R10: ctrl_o changes only as a result of a stored write data byte. Reads leave it unchanged.
- R11: A pulse on SDA or SCL shorter than three system clocks is not seen as a bus event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| strap_i | input | 1 | Address-select strap |
| pwrgd_i | input | 1 | Power-good; first rise latches the strap |
| status_i | input | 2 | Read-only status shown in location 1 [7:6] |
| ctrl_o | output | 32 | Packed writable configuration |

## Verification
The bench aims first at the byte-sequencing edges of the protocol.

If a target ignored the byte count, it would spill surplus write bytes into the next location. If it dropped the count byte on reads, every read would come back shifted by one. If it kept driving after a host NACK, it would corrupt the byte that follows.

Address latching is tested by toggling the strap and power-good after the first rise. A design that re-sampled the strap would move to the other address.

Writes aimed at the read-only, reserved and out-of-range indices must show no effect on ctrl_o or on read-back.

A two-clock SDA glitch is placed inside a high SCL phase. A missing filter would take it for a start and abandon the transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned REG_NUM = 8;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned CNT_W   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_ACK, ST_TX, ST_HACK
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_IDX, PH_CNT, PH_DATA
  } wr_ph_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] win_q;
  logic                out_q;

  // line idles high; output only moves when the whole window agrees
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (&win_q)       out_q <= 1'b1;
      else if (~|win_q) out_q <= 1'b0;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0]       DEF_L0  = 8'hFF,
  parameter logic [5:0]       DEF_L1  = 6'h02,
  parameter logic [7:0]       DEF_L2  = 8'hFF,
  parameter logic [7:0]       DEF_L3  = 8'h10,
  parameter logic [CNT_W-1:0] DEF_CNT = 5'd8,
  parameter logic [7:0]       RO_REV  = 8'h01,
  parameter logic [7:0]       RO_DEV  = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       status_i,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] bcount,
  output logic [31:0]      ctrl
);
  logic [7:0]       l0_q, l2_q, l3_q;
  logic [5:0]       l1_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l0_q  <= DEF_L0;
      l1_q  <= DEF_L1;
      l2_q  <= DEF_L2;
      l3_q  <= DEF_L3;
      cnt_q <= DEF_CNT;
    end else if (wr_en) begin
      case (wr_idx)
        8'd0:    l0_q  <= wr_data;
        8'd1:    l1_q  <= wr_data[5:0];
        8'd2:    l2_q  <= wr_data;
        8'd3:    l3_q  <= wr_data;
        8'd7:    cnt_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      8'd0:    rd_data = l0_q;
      8'd1:    rd_data = {status_i, l1_q};
      8'd2:    rd_data = l2_q;
      8'd3:    rd_data = l3_q;
      8'd5:    rd_data = RO_REV;
      8'd6:    rd_data = RO_DEV;
      8'd7:    rd_data = {{(8-CNT_W){1'b0}}, cnt_q};
      default: rd_data = 8'hFF;
    endcase
  end

  assign bcount = cnt_q;
  assign ctrl   = {l3_q, l2_q, 2'b00, l1_q, l0_q};
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             addr_valid,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] bcount,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);
  localparam int unsigned BIT_W = $clog2(9) + 1;

  bus_st_e          st_q;
  wr_ph_e           ph_q;
  logic             scl_d, sda_d, rd_mode, first_tx, host_ack;
  logic [7:0]       sh_q, remain_q, tx_byte;
  logic [IDX_W-1:0] idx_q;
  logic [BIT_W-1:0] bit_q;
  logic             scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign start_det = scl & scl_d & sda_d & ~sda;
  assign stop_det  = scl & scl_d & ~sda_d & sda;
  assign tx_byte   = first_tx ? {{(8-CNT_W){1'b0}}, bcount} : rd_data;
  assign rd_idx    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= PH_IDX;
      scl_d <= 1'b1;    sda_d <= 1'b1;
      rd_mode <= 1'b0;  first_tx <= 1'b0; host_ack <= 1'b0;
      sh_q <= '0;       remain_q <= '0;   idx_q <= '0;  bit_q <= '0;
      wr_en <= 1'b0;    wr_idx <= '0;     wr_data <= '0; sda_pull <= 1'b0;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
      wr_en <= 1'b0;
      if (stop_det) begin
        st_q <= ST_IDLE;  sda_pull <= 1'b0;
      end else if (start_det) begin
        st_q <= ST_ADDR;  bit_q <= '0;  sda_pull <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda};
              bit_q <= bit_q + 1'b1;
            end else if (scl_fall && bit_q == BIT_W'(8)) begin
              if (st_q == ST_ADDR) begin
                if (addr_valid && sh_q[7:1] == dev_addr) begin
                  sda_pull <= 1'b1;  st_q <= ST_ACK;
                  rd_mode  <= sh_q[0]; first_tx <= 1'b1;
                  if (!sh_q[0]) ph_q <= PH_IDX;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                sda_pull <= 1'b1;  st_q <= ST_ACK;
                case (ph_q)
                  PH_IDX: begin idx_q <= sh_q; ph_q <= PH_CNT; end
                  PH_CNT: begin remain_q <= sh_q; ph_q <= PH_DATA; end
                  default: if (remain_q != 8'd0) begin
                    wr_en    <= 1'b1;  wr_idx <= idx_q;  wr_data <= sh_q;
                    idx_q    <= idx_q + 1'b1;
                    remain_q <= remain_q - 8'd1;
                  end
                endcase
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            bit_q <= '0;
            if (rd_mode) begin
              st_q <= ST_TX;  sh_q <= tx_byte;  sda_pull <= ~tx_byte[7];
              if (first_tx) first_tx <= 1'b0;
              else          idx_q    <= idx_q + 1'b1;
            end else begin
              st_q <= ST_RX;  sda_pull <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) bit_q <= bit_q + 1'b1;
            else if (scl_fall) begin
              if (bit_q == BIT_W'(8)) begin
                sda_pull <= 1'b0;  st_q <= ST_HACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b1};  sda_pull <= ~sh_q[6];
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) host_ack <= ~sda;
            else if (scl_fall) begin
              bit_q <= '0;
              if (host_ack) begin
                st_q <= ST_TX;  sh_q <= tx_byte;  sda_pull <= ~tx_byte[7];
                if (first_tx) first_tx <= 1'b0;
                else          idx_q    <= idx_q + 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE  = 7'h68,
  parameter int unsigned STRAP_BIT = 1,
  parameter int unsigned SYNC_LEN  = 2,
  parameter int unsigned FILT_LEN  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic        strap_i,
  input  logic        pwrgd_i,
  input  logic [1:0]  status_i,
  output logic [31:0] ctrl_o
);
  logic [1:0]       raw_lines, filt_lines;
  logic             scl_f, sda_f, pg_q, addr_valid, wr_en;
  logic [6:0]       dev_addr;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;
  logic [CNT_W-1:0] bcount;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g]));
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  // strap captured once, on the first power-good rise after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;  addr_valid <= 1'b0;  dev_addr <= ADDR_BASE;
    end else begin
      pg_q <= pwrgd_i;
      if (pwrgd_i && !pg_q && !addr_valid) begin
        addr_valid <= 1'b1;
        dev_addr   <= ADDR_BASE | (7'(strap_i) << STRAP_BIT);
      end
    end
  end

  smb_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
    .addr_valid(addr_valid), .dev_addr(dev_addr), .rd_data(rd_data),
    .bcount(bcount), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_pull(sda_pull_o));

  smb_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .status_i(status_i),
    .rd_data(rd_data), .bcount(bcount), .ctrl(ctrl_o));
endmodule

// File: rtl/smb_cfg_target_chk.sv
module smb_cfg_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_f,
  input logic        pwrgd_i,
  input logic        sda_pull_o,
  input logic        wr_en,
  input logic        addr_valid,
  input logic [6:0]  dev_addr,
  input logic [31:0] ctrl_o
);
  logic pg_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pg_seen <= 1'b0;
    else if (pwrgd_i) pg_seen <= 1'b1;
  end

  assert_quiet_before_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_seen |-> !sda_pull_o);

  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_f);

  assert_addr_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> addr_valid && $stable(dev_addr));

  assert_ctrl_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(ctrl_o));
endmodule

bind smb_cfg_target smb_cfg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .pwrgd_i(pwrgd_i),
  .sda_pull_o(sda_pull_o), .wr_en(wr_en), .addr_valid(addr_valid),
  .dev_addr(dev_addr), .ctrl_o(ctrl_o));

// File: tb/smb_cfg_target_tb.sv
module smb_cfg_target_tb;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0, pwrgd = 1'b0;
  logic [1:0] status = 2'b00;
  logic sda_pull;
  logic [31:0] ctrl;
  wire sda_line = sda_m & ~sda_pull;

  smb_cfg_target u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(strap), .pwrgd_i(pwrgd), .status_i(status),
    .ctrl_o(ctrl));

  int n_chk = 0, n_bad = 0, viol = 0;
  logic glitch = 1'b0, prev_pull = 1'b0;
  logic [7:0] m [0:7];
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];

  // R9 monitor: pull must not rise while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_pull && !prev_pull && scl_m) viol++;
    prev_pull <= sda_pull;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] i);
    case (i)
      8'd0, 8'd2, 8'd3, 8'd7: return m[i[2:0]];
      8'd1:    return {status, m[1][5:0]};
      8'd5:    return 8'h01;
      8'd6:    return 8'h04;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  task automatic model_wr(input logic [7:0] i, input logic [7:0] d);
    case (i)
      8'd0, 8'd2, 8'd3: m[i[2:0]] = d;
      8'd1: m[1] = {2'b00, d[5:0]};
      8'd7: m[7] = {3'b000, d[4:0]};
      default: ;
    endcase
  endtask

  task automatic model_reset();
    m[0] = 8'hFF; m[1] = 8'h02; m[2] = 8'hFF; m[3] = 8'h10;
    m[4] = 8'hFF; m[5] = 8'h01; m[6] = 8'h04; m[7] = 8'h08;
  endtask

  task automatic i2c_start();
    if (!scl_m) begin sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); end
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic clk_bit(input logic b, input logic glt, output logic r);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); r = sda_line;
    if (glt) begin sda_m = 1'b0; tick(2); sda_m = b; tick(Q-2); end
    else tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], glitch && i == 7, r);
    clk_bit(1'b1, 1'b0, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic ack_send, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, 1'b0, r); d = {d[6:0], r}; end
    clk_bit(~ack_send, 1'b0, r);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    i2c_start(); wr_byte({a, 1'b0}, ack); i2c_stop();
  endtask

  task automatic blk_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                           input int nb, output int nacks);
    logic ack;
    nacks = 0;
    i2c_start();
    wr_byte({a, 1'b0}, ack); if (!ack) nacks++;
    wr_byte(idx, ack);       if (!ack) nacks++;
    wr_byte(cnt, ack);       if (!ack) nacks++;
    for (int k = 0; k < nb; k++) begin wr_byte(wbuf[k], ack); if (!ack) nacks++; end
    i2c_stop();
  endtask

  task automatic model_blk(input logic [7:0] idx, input logic [7:0] cnt, input int nb);
    for (int k = 0; k < nb; k++) if (k < int'(cnt)) model_wr(idx + 8'(k), wbuf[k]);
  endtask

  task automatic blk_read(input logic [6:0] a, input logic [7:0] idx, input int nr,
                          output logic [7:0] cnt_b, output int nacks);
    logic ack;
    nacks = 0;
    i2c_start();
    wr_byte({a, 1'b0}, ack); if (!ack) nacks++;
    wr_byte(idx, ack);       if (!ack) nacks++;
    i2c_start();
    wr_byte({a, 1'b1}, ack); if (!ack) nacks++;
    rd_byte(1'b1, cnt_b);
    for (int k = 0; k < nr; k++) rd_byte(k != nr - 1, rbuf[k]);
    i2c_stop();
  endtask

  task automatic read_check(input string tag, input logic [7:0] idx, input int nr);
    logic [7:0] cb; int na;
    blk_read(7'h6A, idx, nr, cb, na);
    chk({tag, " read acks"}, na, 0);
    chk({tag, " R4 count byte"}, cb, {3'b000, m[7][4:0]});
    for (int k = 0; k < nr; k++) chk({tag, " R4/R8 data"}, rbuf[k], exp_rd(idx + 8'(k)));
    chk({tag, " R10 ctrl after read"}, ctrl, exp_ctrl());
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(5); rst_n = 1'b1; tick(5); model_reset();
  endtask

  task automatic finish_run();
    chk("R9 pull rose with SCL high", viol, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack; int na; logic [7:0] cb, d;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    do_reset();
    chk("R6 reset ctrl", ctrl, 32'h10FF_02FF);

    probe(7'h68, ack); chk("R2 no ack before power-good", ack, 0);
    pwrgd = 1'b1; tick(4);
    probe(7'h68, ack); chk("R1 strap0 address acked", ack, 1);
    probe(7'h6A, ack); chk("R1 strap0 other address nacked", ack, 0);
    strap = 1'b1; pwrgd = 1'b0; tick(4); pwrgd = 1'b1; tick(4);
    probe(7'h68, ack); chk("R1 address kept after strap change", ack, 1);

    pwrgd = 1'b0; do_reset(); pwrgd = 1'b1; tick(4);
    probe(7'h6A, ack); chk("R1 strap1 address acked", ack, 1);

    status = 2'b10;
    read_check("R6/R7 defaults", 8'd0, 8);

    wbuf[0] = 8'hAA; wbuf[1] = 8'h55; wbuf[2] = 8'h33; wbuf[3] = 8'hCC;
    blk_write(7'h6A, 8'd4, 8'd4, 4, na); model_blk(8'd4, 8'd4, 4);
    chk("R3 acks RO write", na, 0);
    chk("R7 ctrl after RO write", ctrl, exp_ctrl());
    read_check("R7 RO readback", 8'd4, 4);
    wbuf[0] = 8'h08; blk_write(7'h6A, 8'd7, 8'd1, 1, na); model_blk(8'd7, 8'd1, 1);

    wbuf[0] = 8'h3C; wbuf[1] = 8'h3D;
    blk_write(7'h6A, 8'd9, 8'd2, 2, na); model_blk(8'd9, 8'd2, 2);
    chk("R8 write above 7 ignored", ctrl, exp_ctrl());
    read_check("R7 high index", 8'd8, 2);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    blk_write(7'h6A, 8'd0, 8'd1, 2, na); model_blk(8'd0, 8'd1, 2);
    chk("R3 extra byte acked", na, 0);
    chk("R3 extra byte not stored", ctrl, exp_ctrl());

    i2c_start(); wr_byte({7'h68, 1'b0}, ack);
    chk("R2 mismatch nacked", ack, 0);
    wr_byte(8'd0, ack); wr_byte(8'd1, ack); wr_byte(8'h5A, ack);
    chk("R2 traffic after mismatch not acked", ack, 0);
    i2c_stop();
    chk("R2 traffic after mismatch ignored", ctrl, exp_ctrl());

    i2c_start(); wr_byte({7'h6A, 1'b0}, ack); wr_byte(8'd2, ack);
    i2c_start(); wr_byte({7'h6A, 1'b1}, ack);
    rd_byte(1'b1, cb); rd_byte(1'b0, d);
    chk("R5 data before nack", d, exp_rd(8'd2));
    rd_byte(1'b0, d);
    chk("R5 silent after nack", d, 8'hFF);
    i2c_stop();

    glitch = 1'b1; wbuf[0] = 8'hA5;
    blk_write(7'h6A, 8'd2, 8'd1, 1, na);
    glitch = 1'b0; model_blk(8'd2, 8'd1, 1);
    chk("R11 glitch ignored acks", na, 0);
    chk("R11 glitch ignored data", ctrl, exp_ctrl());

    for (int it = 0; it < 12; it++) begin
      logic [7:0] idx, cnt; int nb;
      idx = 8'($urandom_range(0, 9));
      cnt = 8'($urandom_range(0, 4));
      nb  = int'(cnt) + (($urandom_range(0, 3) == 0) ? 1 : 0);
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      status = 2'($urandom);
      blk_write(7'h6A, idx, cnt, nb, na); model_blk(idx, cnt, nb);
      chk("R3 random write acks", na, 0);
      chk("R3/R6 random ctrl", ctrl, exp_ctrl());
      read_check("R4 random", 8'($urandom_range(0, 9)), $urandom_range(1, 3));
    end
    finish_run();
  end
endmodule